// File: doc/BRIEF.md
# Per-Line Policy Direct-Mapped Data Cache

This block is a small data cache that sits between a 32-bit in-order core and a simple word-wide memory port. It holds 1 KB as 64 direct-mapped lines of 16 bytes. Every CPU access carries a 2-bit attribute that picks one of three handlings: write-back, write-through, or cache-inhibited. When a line is filled, the cache records the attribute of the access that caused the fill. Later hits on that line follow the policy stored with the line, not the attribute of the access that hits it.

The CPU side takes one 32-bit word per access, with byte enables. The core raises `cpu_req` and holds all request fields steady while `cpu_stall` is high. The access completes in the first cycle in which `cpu_req` is high and `cpu_stall` is low, and read data is valid in that cycle.

The memory side moves one word per request/acknowledge pair. Line traffic uses this port in two ways: a refill is four word reads, and an eviction of a dirty line is four word writes. A flush input drops every line in a single cycle and discards any dirty data.

Top module: `dm_policy_cache`

## Requirements
- R1: Address bits [3:0] select the byte within a line, bits [9:4] select one of 64 lines, and bits [31:10] form the tag. Two addresses 1024 bytes apart therefore compete for the same line.
- R2: The access attribute is encoded as 00 = write-back, 01 = write-through, 10 or 11 = inhibited. A line keeps the write-back or write-through policy it was filled with, and a hit follows that stored policy regardless of the attribute given with the hitting access.
- R3: A read hit drops `cpu_stall` in the same cycle as the request and returns the addressed word on `cpu_rdata`.
- R4: A cacheable read miss keeps `cpu_stall` high while the line is refilled. The refill is four word reads at line offsets 0, 4, 8 and 12, in that order. The requested word is then returned.
- R5: A write hit on a write-back line updates only the bytes whose `cpu_be` bits are set, marks the line dirty, completes without stalling, and causes no memory traffic.
- R6: A write hit on a write-through line updates the cached bytes and issues exactly one word write to memory, carrying the CPU byte enables. The line never becomes dirty, so evicting it later causes no memory writes.
- R7: A write miss with the write-through attribute causes one memory word write and does not allocate a line. A later read of that address still misses.
- R8: A write miss with the write-back attribute refills the line with four reads and then merges the written bytes into it, leaving the line dirty. Memory is not updated by this access.
- R9: A miss that replaces a valid dirty line first writes the old line's four words to the old address, at offsets 0 through 12 in order, and only then starts the refill.
- R10: An inhibited access performs one word read or write at the word-aligned address. It neither looks up nor allocates a line, so repeating it repeats the memory access.
- R11: When `flush` is high while the cache is idle, every line is invalidated at that clock edge with no memory writes. A request presented in the same cycle stays stalled and is served afterwards as a miss.
- R12: A memory beat is accepted at a clock edge where both `mem_req` and `mem_ack` are high. Until that edge, `mem_req`, `mem_we` and `mem_addr` stay unchanged.
- R13: After reset all lines are invalid and `mem_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all lines (honoured when idle) |
| cpu_req | input | 1 | Access request, held until completion |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_be | input | 4 | Byte enables for writes |
| cpu_wdata | input | 32 | Write data |
| cpu_attr | input | 2 | Access policy attribute (see R2) |
| cpu_rdata | output | 32 | Read data, valid when the access completes |
| cpu_stall | output | 1 | High while the request cannot complete |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Memory beat is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory write byte enables |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory beat acknowledge |

## Verification
Directed sequences drive each hit and miss case under each of the three policies. For every case the bench records the exact list of memory beats and compares it against the expected list, so a wrong beat order, a missing eviction or an extra write-through shows up as a wrong address or direction, not only as wrong data. One conflicting pair of addresses separates clean replacement from dirty replacement. A deliberate mismatch between the access attribute and a line's stored policy shows which of the two the hit follows. Two flush tests cover a flush over dirty data (the data must be lost) and a flush arriving in the same cycle as a request. Random traffic then mixes the three address regions and shares a small set of indexes between them, so conflict evictions occur often. Every read is checked against a byte-level reference of what the CPU last wrote, and after each write-through or inhibited write the memory contents are checked as well.

// File: rtl/dm_policy_cache.sv
`timescale 1ns/1ps
module dm_policy_cache #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LINES = 64,
  parameter int WORDS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            cpu_req,
  input  logic            cpu_we,
  input  logic [AW-1:0]   cpu_addr,
  input  logic [DW/8-1:0] cpu_be,
  input  logic [DW-1:0]   cpu_wdata,
  input  logic [1:0]      cpu_attr,
  output logic [DW-1:0]   cpu_rdata,
  output logic            cpu_stall,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic [DW/8-1:0] mem_be,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ack
);
  localparam int BW = DW / 8;
  localparam int SW = $clog2(BW);
  localparam int WW = $clog2(WORDS);
  localparam int IW = $clog2(LINES);
  localparam int OW = SW + WW;
  localparam int TW = AW - IW - OW;

  typedef enum logic [2:0] {IDLE, EVICT, FILL, WORD, RESP} st_t;
  st_t st;

  logic [TW-1:0]    tag_q [LINES];
  logic [DW-1:0]    dat_q [LINES][WORDS];
  logic [LINES-1:0] val_q, dirty_q, wt_q;
  logic [WW-1:0]    cnt;
  logic [DW-1:0]    resp_q;
  logic [DW-1:0]    merged;

  wire [IW-1:0] idx      = cpu_addr[OW +: IW];
  wire [WW-1:0] wsel     = cpu_addr[SW +: WW];
  wire [TW-1:0] tag      = cpu_addr[AW-1 -: TW];
  wire          uncached = cpu_attr[1];
  wire          want_wt  = cpu_attr == 2'b01;
  wire          hit      = val_q[idx] && tag_q[idx] == tag;
  wire          line_wt  = wt_q[idx];
  wire          idle_go  = st == IDLE && cpu_req && !flush;
  wire          fast     = idle_go && !uncached && hit && !(cpu_we && line_wt);
  wire          last     = cnt == WW'(WORDS - 1);

  for (genvar b = 0; b < BW; b++) begin : g_merge
    assign merged[8*b +: 8] = cpu_be[b] ? cpu_wdata[8*b +: 8] : dat_q[idx][wsel][8*b +: 8];
  end

  assign cpu_stall = cpu_req && !(fast || st == RESP);
  assign cpu_rdata = st == RESP ? resp_q : dat_q[idx][wsel];

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    mem_be    = '0;
    case (st)
      EVICT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {tag_q[idx], idx, cnt, {SW{1'b0}}};
        mem_wdata = dat_q[idx][cnt];
        mem_be    = '1;
      end
      FILL: begin
        mem_req  = 1'b1;
        mem_addr = {tag, idx, cnt, {SW{1'b0}}};
        mem_be   = '1;
      end
      WORD: begin
        mem_req   = 1'b1;
        mem_we    = cpu_we;
        mem_addr  = {cpu_addr[AW-1:SW], {SW{1'b0}}};
        mem_wdata = cpu_wdata;
        mem_be    = cpu_be;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      cnt     <= '0;
      resp_q  <= '0;
      val_q   <= '0;
      dirty_q <= '0;
      wt_q    <= '0;
    end else begin
      case (st)
        IDLE:
          if (flush) begin
            val_q   <= '0;
            dirty_q <= '0;
          end else if (cpu_req) begin
            cnt <= '0;
            if (uncached) st <= WORD;
            else if (hit) begin
              if (cpu_we) begin
                dirty_q[idx] <= !line_wt;
                if (line_wt) st <= WORD;
              end
            end
            else if (cpu_we && want_wt) st <= WORD;
            else if (val_q[idx] && dirty_q[idx]) st <= EVICT;
            else st <= FILL;
          end
        EVICT:
          if (mem_ack) begin
            cnt <= cnt + WW'(1);
            if (last) st <= FILL;
          end
        FILL:
          if (mem_ack) begin
            cnt <= cnt + WW'(1);
            if (last) begin
              st           <= IDLE;
              val_q[idx]   <= 1'b1;
              dirty_q[idx] <= 1'b0;
              wt_q[idx]    <= want_wt;
            end
          end
        WORD:
          if (mem_ack) begin
            resp_q <= mem_rdata;
            st     <= RESP;
          end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == FILL && mem_ack) begin
      dat_q[idx][cnt] <= mem_rdata;
      if (last) tag_q[idx] <= tag;
    end
    if (idle_go && !uncached && hit && cpu_we) dat_q[idx][wsel] <= merged;
  end

  a_r13_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !mem_req);

  a_r9_evict_order: assert property (@(posedge clk) disable iff (!rst_n)
    st == EVICT && mem_ack && !last |=>
      mem_req && mem_we && mem_addr[SW +: WW] == WW'($past(mem_addr[SW +: WW]) + WW'(1)));

  a_r9_evict_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
    st == EVICT && mem_ack && last |=> mem_req && !mem_we && mem_addr[SW +: WW] == '0);

  a_r4_fill_order: assert property (@(posedge clk) disable iff (!rst_n)
    st == FILL && mem_ack && !last |=>
      mem_req && !mem_we && mem_addr[SW +: WW] == WW'($past(mem_addr[SW +: WW]) + WW'(1)));

  a_r3_hit_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    st == FILL && mem_ack && last && cpu_req && !cpu_we |=> flush || !cpu_stall);

  a_r6_wt_never_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty_q & wt_q) == '0);

  a_r11_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    st == IDLE && flush |=> val_q == '0 && !mem_req);

  a_r12_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  a_r10_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    idle_go && uncached |=> mem_req && mem_addr == {$past(cpu_addr[AW-1:SW]), {SW{1'b0}}});
endmodule

// File: tb/sim_dm_policy_cache.sv
`timescale 1ns/1ps
module sim_dm_policy_cache;
  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [3:0] cpu_be = '0;
  logic [1:0] cpu_attr = '0;
  logic [31:0] cpu_rdata, mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic cpu_stall, mem_req, mem_we;
  logic mem_ack = 1'b0;
  logic [3:0] mem_be;

  dm_policy_cache u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_be(cpu_be),
    .cpu_wdata(cpu_wdata), .cpu_attr(cpu_attr), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_ack(mem_ack));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] mem [int unsigned];
  logic [31:0] refm [int unsigned];
  logic [31:0] tx_addr [16];
  logic tx_we [16];
  int tx_n = 0;

  function automatic logic [31:0] seed_val(int unsigned wa);
    return (wa * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction
  function automatic logic [31:0] mread(int unsigned wa);
    return mem.exists(wa) ? mem[wa] : seed_val(wa);
  endfunction
  function automatic logic [31:0] rread(int unsigned wa);
    return refm.exists(wa) ? refm[wa] : seed_val(wa);
  endfunction
  function automatic logic [31:0] mergeb(logic [31:0] o, logic [31:0] d, logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction
  function automatic logic [1:0] attr_of(logic [31:0] a);
    return a[13:12] == 2'd0 ? 2'b00 : a[13:12] == 2'd1 ? 2'b01 : 2'b10;
  endfunction
  function automatic int writes_seen();
    int c = 0;
    for (int i = 0; i < 16; i++) if (i < tx_n && tx_we[i]) c++;
    return c;
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  initial begin
    int unsigned wa;
    forever begin
      @(negedge clk); #2;
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req && $urandom_range(0, 3) != 0) begin
        wa = mem_addr >> 2;
        if (tx_n < 16) begin
          tx_addr[tx_n] = mem_addr;
          tx_we[tx_n] = mem_we;
        end
        tx_n++;
        if (mem_we) mem[wa] = mergeb(mread(wa), mem_wdata, mem_be);
        else mem_rdata = mread(wa);
        mem_ack = 1'b1;
      end
    end
  end

  task automatic acc_a(input logic we, input logic [31:0] a, input logic [3:0] be,
                       input logic [31:0] wd, input logic [1:0] at,
                       output logic [31:0] rd, output int n);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_be = be; cpu_wdata = wd; cpu_attr = at;
    tx_n = 0; n = 0;
    #1;
    while (cpu_stall && n < 2000) begin @(negedge clk); #1; n++; end
    rd = cpu_rdata;
    @(negedge clk);
    cpu_req = 1'b0;
    if (we) refm[a >> 2] = mergeb(rread(a >> 2), wd, be);
  endtask

  task automatic acc(input logic we, input logic [31:0] a, input logic [3:0] be,
                     input logic [31:0] wd, output logic [31:0] rd, output int n);
    acc_a(we, a, be, wd, attr_of(a), rd, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, m;
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R13 mem_req low in reset", mem_req, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R13 mem_req low after reset", mem_req, 0);
    chk("R13 no stall without request", cpu_stall, 0);

    acc(0, 32'h100, 4'h0, 0, rd, n);
    chk("R13 first access misses", n > 0, 1);
    chk("R4 refill beat count", tx_n, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R4 refill beat address", tx_addr[i], 32'h100 + 4 * i);
      chk("R4 refill beat is read", tx_we[i], 0);
    end
    chk("R4 miss data", rd, rread(32'h100 >> 2));

    acc(0, 32'h104, 4'h0, 0, rd, n);
    chk("R3 read hit no stall", n, 0);
    chk("R3 read hit no traffic", tx_n, 0);
    chk("R3 read hit data", rd, rread(32'h104 >> 2));

    acc(1, 32'h108, 4'b0011, 32'hCAFEBEEF, rd, n);
    chk("R5 wb write hit no stall", n, 0);
    chk("R5 wb write hit no traffic", tx_n, 0);
    chk("R5 memory untouched", mread(32'h108 >> 2), seed_val(32'h108 >> 2));
    m = mergeb(seed_val(32'h108 >> 2), 32'hCAFEBEEF, 4'b0011);
    acc(0, 32'h108, 4'h0, 0, rd, n);
    chk("R5 byte merge", rd, m);

    acc(0, 32'h500, 4'h0, 0, rd, n);
    chk("R9 evict plus refill beats", tx_n, 8);
    for (int i = 0; i < 4; i++) begin
      chk("R9 evict address order", tx_addr[i], 32'h100 + 4 * i);
      chk("R9 evict is write", tx_we[i], 1);
      chk("R1 conflicting refill address", tx_addr[i + 4], 32'h500 + 4 * i);
      chk("R9 refill after evict is read", tx_we[i + 4], 0);
    end
    chk("R9 dirty word reached memory", mread(32'h108 >> 2), m);
    chk("R1 conflict read data", rd, rread(32'h500 >> 2));

    acc(0, 32'h1200, 4'h0, 0, rd, n);
    acc(1, 32'h1204, 4'hF, 32'h11223344, rd, n);
    chk("R6 wt hit one beat", tx_n, 1);
    chk("R6 wt hit beat is write", tx_we[0], 1);
    chk("R6 wt hit address", tx_addr[0], 32'h1204);
    chk("R6 wt memory updated", mread(32'h1204 >> 2), 32'h11223344);
    acc(0, 32'h1204, 4'h0, 0, rd, n);
    chk("R6 wt cache updated", rd, 32'h11223344);
    acc(0, 32'h1600, 4'h0, 0, rd, n);
    chk("R6 wt line evicts clean", writes_seen(), 0);
    chk("R6 refill only", tx_n, 4);

    acc(1, 32'h1A40, 4'b1100, 32'hA5A55A5A, rd, n);
    chk("R7 wt miss one beat", tx_n, 1);
    chk("R7 wt miss is write", tx_we[0], 1);
    chk("R7 memory written", mread(32'h1A40 >> 2), rread(32'h1A40 >> 2));
    acc(0, 32'h1A40, 4'h0, 0, rd, n);
    chk("R7 no allocation", tx_n, 4);
    chk("R7 read after wt miss", rd, rread(32'h1A40 >> 2));

    acc(1, 32'h0280, 4'b0101, 32'h0BADF00D, rd, n);
    chk("R8 wb write miss refill", tx_n, 4);
    chk("R8 no memory write", writes_seen(), 0);
    chk("R8 memory untouched", mread(32'h280 >> 2), seed_val(32'h280 >> 2));
    acc(0, 32'h0280, 4'h0, 0, rd, n);
    chk("R8 allocated line hits", n, 0);
    chk("R8 merged data", rd, rread(32'h280 >> 2));

    acc_a(1, 32'h0284, 4'hF, 32'h600DCAFE, 2'b01, rd, n);
    chk("R2 stored wb policy wins", tx_n, 0);
    chk("R2 no stall on stored wb", n, 0);

    acc(0, 32'h2300, 4'h0, 0, rd, n);
    chk("R10 inhibited single read", tx_n, 1);
    chk("R10 inhibited read data", rd, mread(32'h2300 >> 2));
    acc(0, 32'h2300, 4'h0, 0, rd, n);
    chk("R10 inhibited not allocated", tx_n, 1);
    acc(1, 32'h2304, 4'hF, 32'h00000077, rd, n);
    chk("R10 inhibited write beat", tx_we[0], 1);
    chk("R10 inhibited memory", mread(32'h2304 >> 2), 32'h77);

    @(negedge clk);
    tx_n = 0;
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 flush no write back", tx_n, 0);
    refm = mem;
    acc(0, 32'h0280, 4'h0, 0, rd, n);
    chk("R11 flushed line misses", n > 0, 1);
    chk("R11 dirty data dropped", rd, seed_val(32'h280 >> 2));

    @(negedge clk);
    tx_n = 0;
    flush = 1'b1;
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 32'h284; cpu_be = 0; cpu_attr = 2'b00;
    #1;
    chk("R11 request held during flush", cpu_stall, 1);
    @(negedge clk);
    flush = 1'b0;
    n = 0;
    #1;
    while (cpu_stall && n < 2000) begin @(negedge clk); #1; n++; end
    chk("R11 served as miss", tx_n, 4);
    chk("R11 data after flush", cpu_rdata, rread(32'h284 >> 2));
    @(negedge clk);
    cpu_req = 1'b0;

    for (int k = 0; k < 400; k++) begin
      logic [31:0] a;
      logic w;
      a = ($urandom_range(0, 2) << 12) | ($urandom_range(0, 1) << 10) |
          ($urandom_range(0, 5) << 4) | ($urandom_range(0, 3) << 2);
      w = $urandom_range(0, 2) == 0;
      acc(w, a, 4'($urandom_range(0, 15)), $urandom, rd, n);
      if (!w) chk("R2 random read data", rd, rread(a >> 2));
      else if (attr_of(a) != 2'b00) chk("R6 random memory after write", mread(a >> 2), rread(a >> 2));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule